// File: doc/BRIEF.md
# Clock Source Select Control Register

This block is a 16-bit control and status register for a clock subsystem. Software reads the active clock source and the PLL lock state. It writes a requested source and starts a switch. The oscillators, the PLL and the clock-fail monitor live outside the block. They reach it as status inputs and as a one-cycle switch-done pulse from the switching logic.

Writes are protected. A two-key sequence on a separate key port opens a short window, and that window admits exactly one register write. A lock bit can also freeze the source selection, but only when a configuration input allows it. A switch request that would hop directly between the two PLL-based sources is refused. The refusal is reported through a one-cycle status pulse.

Top module: `clksel_ctrl`

## Requirements
- R1: The read word places the current source at bits 14:12, the requested source at 10:8, the lock bit at 7, PLL lock at 5, clock-fail at 3, low-power secondary enable at 1 and switch enable at 0. Bits 15, 11, 6, 4 and 2 read 0. Source codes are: 0 fast RC, 1 fast RC with PLL, 2 primary, 3 primary with PLL, 4 secondary, 5 low-power RC, 6 fast RC divided by 16, 7 fast RC with programmable divider.
- R2: A synchronous active-high reset loads both source fields from `cfg_src` and clears every other stored bit.
- R3: A register write that arrives while no unlock window is open changes nothing.
- R4: Key 0x46 followed by key 0x57 on the next key-port write opens the window. Any other key order leaves it closed.
- R5: The window is open for the four cycles that follow the 0x57 key cycle. It closes after the first write accepted inside it.
- R6: Writing 1 to bit 0 while no switch is pending raises `sw_req`, with `sw_target` equal to the requested field. The bit stays 1 until `sw_done` pulses. On that pulse the current field takes the requested value and bit 0 clears. `sw_done` with no switch pending is ignored, and software cannot clear bit 0.
- R7: `fail_det` sets the clock-fail bit. An accepted write of 0 to bit 3 clears it and a write of 1 leaves it. `fail_det` wins a tie.
- R8: Bit 5 follows `pll_locked` in the same cycle, and writes do not affect it.
- R9: A pending switch between codes 1 and 3, in either direction, is dropped. Bit 0 clears one cycle after it was set, `illegal_sw` pulses for one cycle, and the current source is unchanged.
- R10: With the lock bit at 1 and `cfg_lock_en` at 1, writes to the requested field, the lock bit and bit 0 are ignored. With `cfg_lock_en` at 0 they stay writable.
- R11: The low-power secondary enable and the clock-fail clear are writable through any accepted write, whether or not the register is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src | input | 3 | Reset value of both source fields |
| cfg_lock_en | input | 1 | Allows the lock bit to freeze the selection |
| key_wr | input | 1 | Key port write strobe |
| key_data | input | 8 | Key value |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| pll_locked | input | 1 | PLL lock or start-up timer done |
| fail_det | input | 1 | Clock-fail detect pulse |
| sw_done | input | 1 | Switch completed pulse |
| sw_req | output | 1 | Switch pending |
| sw_target | output | 3 | Requested source |
| illegal_sw | output | 1 | Refused PLL-to-PLL switch pulse |

## Verification
The forbidden PLL-to-PLL hop is the hardest case to reach. The current source must first sit on a PLL mode, which takes a legal switch completed by a `sw_done` pulse. Only then can a second protected write request the other PLL mode. The stimulus walks fast RC, then fast RC with PLL, then requests primary with PLL. It then walks a legal route to primary with PLL and requests the reverse hop. The window edges are hit by writing in the fourth and in the fifth cycle after the key.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
  localparam int SRC_W    = 3;
  localparam int REG_W    = 16;
  localparam int CUR_LO   = 12;
  localparam int REQ_LO   = 8;
  localparam int LOCK_BIT = 7;
  localparam int PLL_BIT  = 5;
  localparam int FAIL_BIT = 3;
  localparam int LPO_BIT  = 1;
  localparam int SWEN_BIT = 0;

  typedef enum logic [SRC_W-1:0] {
    SRC_FRC       = 3'd0,
    SRC_FRC_PLL   = 3'd1,
    SRC_PRI       = 3'd2,
    SRC_PRI_PLL   = 3'd3,
    SRC_SEC       = 3'd4,
    SRC_LPRC      = 3'd5,
    SRC_FRC_DIV16 = 3'd6,
    SRC_FRC_DIVN  = 3'd7
  } clk_src_e;

  // true when moving between the two PLL-fed sources
  function automatic logic pll_hop(input logic [SRC_W-1:0] from_s,
                                   input logic [SRC_W-1:0] to_s);
    return ((from_s == SRC_FRC_PLL) && (to_s == SRC_PRI_PLL)) ||
           ((from_s == SRC_PRI_PLL) && (to_s == SRC_FRC_PLL));
  endfunction
endpackage

// File: rtl/clksel_unlock.sv
`timescale 1ns/1ps
module clksel_unlock #(
  parameter int               KEY_W      = 8,
  parameter logic [KEY_W-1:0] KEY_A      = 8'h46,
  parameter logic [KEY_W-1:0] KEY_B      = 8'h57,
  parameter int               WIN_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_data,
  input  logic             consume,
  output logic             open
);
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);

  logic             armed;
  logic [CNT_W-1:0] win_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      win_cnt <= '0;
    end else begin
      if (consume)
        win_cnt <= '0;
      else if (win_cnt != '0)
        win_cnt <= win_cnt - 1'b1;
      if (key_wr) begin
        if (armed && (key_data == KEY_B)) begin
          win_cnt <= CNT_W'(WIN_CYCLES);
          armed   <= 1'b0;
        end else begin
          armed <= (key_data == KEY_A);
        end
      end
    end
  end

  assign open = (win_cnt != '0);
endmodule

// File: rtl/clksel_switch.sv
`timescale 1ns/1ps
module clksel_switch
  import clksel_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] cfg_src,
  input  logic [SRC_W-1:0] req_src,
  input  logic             start,
  input  logic             sw_done,
  output logic [SRC_W-1:0] cur_src,
  output logic             busy,
  output logic             illegal
);
  logic hop;
  assign hop = busy && pll_hop(cur_src, req_src);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_src <= cfg_src;
      busy    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      illegal <= hop;
      if (hop) begin
        busy <= 1'b0;
      end else if (busy && sw_done) begin
        cur_src <= req_src;
        busy    <= 1'b0;
      end else if (start && !busy) begin
        busy <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/clksel_ctrl.sv
`timescale 1ns/1ps
module clksel_ctrl
  import clksel_pkg::*;
#(
  parameter int               KEY_W      = 8,
  parameter logic [KEY_W-1:0] KEY_A      = 8'h46,
  parameter logic [KEY_W-1:0] KEY_B      = 8'h57,
  parameter int               WIN_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cfg_src,
  input  logic             cfg_lock_en,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_data,
  input  logic             reg_wr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic             pll_locked,
  input  logic             fail_det,
  input  logic             sw_done,
  output logic             sw_req,
  output logic [2:0]       sw_target,
  output logic             illegal_sw
);
  logic             win_open, accept, frozen, start;
  logic [SRC_W-1:0] req_q, cur_src;
  logic             lock_q, fail_q, lpo_q;
  logic             unused_wbits;

  assign accept = reg_wr && win_open;
  assign frozen = lock_q && cfg_lock_en;
  assign start  = accept && !frozen && reg_wdata[SWEN_BIT];
  assign unused_wbits = ^{reg_wdata[15], reg_wdata[14:12], reg_wdata[11],
                          reg_wdata[6:4], reg_wdata[2]};

  clksel_unlock #(
    .KEY_W(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B), .WIN_CYCLES(WIN_CYCLES)
  ) u_unlock (
    .clk(clk), .rst(rst), .key_wr(key_wr), .key_data(key_data),
    .consume(accept), .open(win_open)
  );

  clksel_switch u_switch (
    .clk(clk), .rst(rst), .cfg_src(cfg_src), .req_src(req_q),
    .start(start), .sw_done(sw_done), .cur_src(cur_src),
    .busy(sw_req), .illegal(illegal_sw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= cfg_src;
      lock_q <= 1'b0;
      fail_q <= 1'b0;
      lpo_q  <= 1'b0;
    end else begin
      if (accept && !frozen) begin
        req_q  <= reg_wdata[REQ_LO +: SRC_W];
        lock_q <= reg_wdata[LOCK_BIT];
      end
      if (accept)
        lpo_q <= reg_wdata[LPO_BIT];
      if (fail_det)
        fail_q <= 1'b1;
      else if (accept && !reg_wdata[FAIL_BIT])
        fail_q <= 1'b0;
    end
  end

  assign sw_target = req_q;

  always_comb begin
    reg_rdata                     = '0;
    reg_rdata[CUR_LO +: SRC_W]    = cur_src;
    reg_rdata[REQ_LO +: SRC_W]    = req_q;
    reg_rdata[LOCK_BIT]           = lock_q;
    reg_rdata[PLL_BIT]            = pll_locked;
    reg_rdata[FAIL_BIT]           = fail_q;
    reg_rdata[LPO_BIT]            = lpo_q;
    reg_rdata[SWEN_BIT]           = sw_req;
  end
endmodule

// File: rtl/clksel_chk.sv
`timescale 1ns/1ps
module clksel_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic        fail_det,
  input logic        sw_done,
  input logic [15:0] reg_rdata,
  input logic        sw_req,
  input logic        illegal_sw
);
  logic [2:0] cur;
  assign cur = reg_rdata[14:12];

  // R1
  zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[15] == 1'b0) && (reg_rdata[11] == 1'b0) && (reg_rdata[6] == 1'b0) &&
    (reg_rdata[4] == 1'b0) && (reg_rdata[2] == 1'b0));

  // R4
  swen_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(sw_req)) |-> $past(reg_wr));

  // R6
  cur_change_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (cur != $past(cur))) |-> $past(sw_req && sw_done));

  // R7
  fail_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(reg_rdata[3])) |-> $past(fail_det));

  // R9
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_sw |=> !illegal_sw);

  // R9
  no_pll_hop_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (cur != $past(cur))) |->
      !((($past(cur) == 3'd1) && (cur == 3'd3)) || (($past(cur) == 3'd3) && (cur == 3'd1))));

  // R9
  reject_clear_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_sw |-> !sw_req);
endmodule

bind clksel_ctrl clksel_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .fail_det(fail_det),
  .sw_done(sw_done), .reg_rdata(reg_rdata), .sw_req(sw_req),
  .illegal_sw(illegal_sw)
);

// File: tb/sim_clksel_ctrl.sv
`timescale 1ns/1ps
module sim_clksel_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_src = 3'd2;
  logic        cfg_lock_en = 1'b0;
  logic        key_wr = 1'b0;
  logic [7:0]  key_data = 8'h00;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0000;
  logic [15:0] reg_rdata;
  logic        pll_locked = 1'b0;
  logic        fail_det = 1'b0;
  logic        sw_done = 1'b0;
  logic        sw_req;
  logic [2:0]  sw_target;
  logic        illegal_sw;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;
  string tag = "R2";

  always #2.5 clk = ~clk;

  clksel_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_src(cfg_src), .cfg_lock_en(cfg_lock_en),
    .key_wr(key_wr), .key_data(key_data), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pll_locked(pll_locked), .fail_det(fail_det),
    .sw_done(sw_done), .sw_req(sw_req), .sw_target(sw_target), .illegal_sw(illegal_sw)
  );

  // behavioural reference model
  int m_cur, m_req, m_lk, m_fl, m_lp, m_sw, m_ill, m_arm, m_cnt, o_sw, o_req;
  bit acc, frz, forb, started = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cur = cfg_src; m_req = cfg_src; m_lk = 0; m_fl = 0; m_lp = 0;
      m_sw = 0; m_ill = 0; m_arm = 0; m_cnt = 0;
    end else begin
      acc  = reg_wr && (m_cnt > 0);
      frz  = (m_lk == 1) && cfg_lock_en;
      forb = (m_sw == 1) && (((m_cur == 1) && (m_req == 3)) || ((m_cur == 3) && (m_req == 1)));
      o_sw = m_sw; o_req = m_req;
      m_ill = forb ? 1 : 0;
      if (forb) m_sw = 0;
      else if ((o_sw == 1) && sw_done) begin m_cur = o_req; m_sw = 0; end
      else if (acc && !frz && reg_wdata[0] && (o_sw == 0)) m_sw = 1;
      if (acc && !frz) begin m_req = reg_wdata[10:8]; m_lk = reg_wdata[7]; end
      if (acc) begin
        m_lp = reg_wdata[1];
        if (!reg_wdata[3]) m_fl = 0;
      end
      if (fail_det) m_fl = 1;
      if (acc) m_cnt = 0; else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (key_wr) begin
        if ((m_arm == 1) && (key_data == 8'h57)) begin m_cnt = 4; m_arm = 0; end
        else m_arm = (key_data == 8'h46) ? 1 : 0;
      end
    end
    started = 1;
  end

  function automatic logic [15:0] model_word();
    return 16'((m_cur << 12) | (m_req << 8) | (m_lk << 7) | (int'(pll_locked) << 5) |
               (m_fl << 3) | (m_lp << 1) | m_sw);
  endfunction

  always @(negedge clk) begin
    if (started && !done_flag) begin
      checks++;
      if (reg_rdata !== model_word() || sw_req !== m_sw[0] ||
          sw_target !== m_req[2:0] || illegal_sw !== m_ill[0]) begin
        errors++;
        $display("FAIL %s model rdata/req/tgt/ill act=%h/%b/%0d/%b exp=%h/%0d/%0d/%0d",
                 tag, reg_rdata, sw_req, sw_target, illegal_sw, model_word(), m_sw, m_req, m_ill);
      end
    end
  end

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic key(input logic [7:0] k);
    key_wr = 1'b1; key_data = k; cyc(); key_wr = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d);
    reg_wr = 1'b1; reg_wdata = d; cyc(); reg_wr = 1'b0;
  endtask

  task automatic uwr(input logic [15:0] d);
    key(8'h46); key(8'h57); wr(d);
  endtask

  task automatic pulse_done();
    sw_done = 1'b1; cyc(); sw_done = 1'b0;
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    tag = "R2"; chk("R2 R1 reset word", reg_rdata, 16'h2200);
    tag = "R3"; wr(16'h0001);
    chk("R3 write without key", reg_rdata, 16'h2200);
    tag = "R6"; uwr(16'h0001);
    chk("R4 R6 switch pending", reg_rdata, 16'h2001);
    cyc(); cyc();
    chk("R6 held until done", {15'd0, sw_req}, 16'h0001);
    pulse_done();
    chk("R6 switch complete", reg_rdata, 16'h0000);
    uwr(16'h0400);
    chk("R6 target", {13'd0, sw_target}, 16'h0004);
    pulse_done();
    chk("R6 idle done ignored", reg_rdata, 16'h0400);
    tag = "R5"; key(8'h46); key(8'h57); repeat (4) cyc(); wr(16'h0500);
    chk("R5 write after window", reg_rdata, 16'h0400);
    key(8'h46); key(8'h57); repeat (3) cyc(); wr(16'h0500);
    chk("R5 write in last window cycle", reg_rdata, 16'h0500);
    wr(16'h0600);
    chk("R5 window consumed", reg_rdata, 16'h0500);
    tag = "R4"; key(8'h57); key(8'h46); key(8'h00); key(8'h57); wr(16'h0600);
    chk("R4 bad key order", reg_rdata, 16'h0500);
    tag = "R8"; pll_locked = 1'b1; cyc();
    chk("R8 pll bit live", reg_rdata, 16'h0520);
    uwr(16'h0500);
    chk("R8 write ignores pll bit", reg_rdata, 16'h0520);
    pll_locked = 1'b0; cyc();
    tag = "R7"; fail_det = 1'b1; cyc(); fail_det = 1'b0;
    chk("R7 fail set", reg_rdata, 16'h0508);
    uwr(16'h0508);
    chk("R7 write 1 keeps", reg_rdata, 16'h0508);
    uwr(16'h0500);
    chk("R7 write 0 clears", reg_rdata, 16'h0500);
    tag = "R9"; uwr(16'h0101); pulse_done();
    chk("R9 on fast RC PLL", reg_rdata, 16'h1100);
    uwr(16'h0301);
    chk("R9 request pending", reg_rdata, 16'h1301);
    cyc();
    chk("R9 rejected", {reg_rdata[15:1], illegal_sw}, 16'h1301);
    cyc();
    chk("R9 pulse ends", {15'd0, illegal_sw}, 16'h0000);
    uwr(16'h0001); pulse_done(); uwr(16'h0301); pulse_done();
    chk("R9 legal route", reg_rdata, 16'h3300);
    uwr(16'h0101); cyc();
    chk("R9 reverse rejected", {reg_rdata[15:1], illegal_sw}, 16'h3101);
    tag = "R10"; uwr(16'h0380);
    chk("R10 lock set", reg_rdata, 16'h3380);
    uwr(16'h0200);
    chk("R10 writable when cfg off", reg_rdata, 16'h3200);
    cfg_lock_en = 1'b1; uwr(16'h0280);
    chk("R10 lock again", reg_rdata, 16'h3280);
    uwr(16'h0401);
    chk("R10 frozen", {reg_rdata[15:1], sw_req}, 16'h3280);
    tag = "R11"; uwr(16'h0482);
    chk("R11 lposc while locked", reg_rdata, 16'h3282);
    tag = "R2"; cfg_src = 3'd5; rst = 1'b1; cyc(); cyc(); rst = 1'b0; cyc();
    chk("R2 reset from cfg", reg_rdata, 16'h5500);
    cyc();
    finish_run();
  end
endmodule